// File: doc/BRIEF.md
# PTP Egress Correction Field Updater

This block sits in a transmit byte path whose first byte of each frame is byte 0 of a version 2 precision time protocol header. It holds the first sixteen header bytes and decides whether the frame is waiting for a residence time adjustment. If it is, the block adds the time the frame spent inside the device to the 64-bit correctionField before the bytes move on.

A frame qualifies only when three conditions hold together. Bit 7 of a reserved header byte, set earlier at ingress, must be set. A 16-bit mask must enable the frame's message type. The header version must match a configured value. On a corrected frame the block also clears that reserved bit, so that later hops do not apply the correction a second time. Bytes after the sixteenth pass straight through. A small configuration (type mask, version, reserved byte offset) and a residence time in nanoseconds come in as sideband inputs.

Top module: `ptp_cf_updater`

## Requirements
- R1: A frame of 16 bytes or more whose reserved flag byte has bit 7 clear leaves the block byte for byte unchanged.
- R2: The reserved flag byte is header byte number `cfg_flag_offset`. Only offsets 2 to 7 are legal. With any other offset the frame is never corrected.
- R3: Correction needs `cfg_type_en[t]` = 1, where t is the low nibble of header byte 0 (messageType). A clear mask bit leaves the frame unchanged.
- R4: Correction needs the low nibble of header byte 1 (versionPTP) to equal `cfg_version`. A `cfg_version` of 0 accepts any version.
- R5: On a qualifying frame, bytes 8 to 15 form a big-endian 64-bit value. They are replaced by that value plus `residence_ns` shifted left by 16, modulo 2^64.
- R6: On a qualifying frame, bit 7 of the reserved flag byte is 0 on output. All other bits of that byte are kept.
- R7: Frames shorter than 16 bytes, and every byte from index 16 onward, pass unchanged.
- R8: Each output frame carries `out_sof` on its first byte only and `out_eof` on its last byte only. Its length equals the input length.
- R9: While `out_valid` is high and `out_ready` is low, the output byte and its markers hold steady. No byte is lost or duplicated under any backpressure pattern.
- R10: Header bytes 2 to 7, apart from the flag bit, have no effect on the decision.
- R11: After reset, `out_valid` is 0 and the block is ready to accept the first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts the input byte |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | Output byte is the first of a frame |
| out_eof | output | 1 | Output byte is the last of a frame |
| cfg_type_en | input | 16 | Per-messageType correction enable |
| cfg_version | input | 4 | Required version, 0 accepts any version |
| cfg_flag_offset | input | 6 | Header index of the reserved flag byte |
| residence_ns | input | RES_W | Residence time in nanoseconds |

## Verification
The adder is tried on qualifying frames with random correction values and residence times. One directed frame has an all-ones correctionField, which separates true 64-bit wraparound from a truncated or saturating sum. Separate frames vary one qualifier at a time: flag clear, mask bit clear, version mismatch, version 0 with a version 1 nibble, offsets 0, 1, 7 and 8. Each of these shows whether that gate alone blocks or allows the rewrite. Frames of 10, 16 and 40 bytes under light and heavy output backpressure separate correct buffering and pass-through from lost, repeated or misplaced bytes.

// File: rtl/ptp_cf_pkg.sv
package ptp_cf_pkg;

    localparam int HDR_LEN  = 16;
    localparam int CF_FIRST = 8;
    localparam int CF_BYTES = 8;
    localparam int CNT_W    = $clog2(HDR_LEN + 1);
    localparam int RD_W     = $clog2(HDR_LEN);
    localparam int LAST_QUAL_IDX = CF_FIRST - 1;

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_PASS  = 2'd2
    } cf_state_e;

    typedef struct packed {
        cf_state_e                 st;
        logic [CNT_W-1:0]          cnt;
        logic [RD_W-1:0]           rd;
        logic                      sof_buf;
        logic                      eof_buf;
        logic                      qual;
        logic [2:0]                off;
        logic [HDR_LEN-1:0][7:0]   hdr;
    } cf_regs_t;

endpackage

// File: rtl/ptp_cf_qualify.sv
module ptp_cf_qualify
    import ptp_cf_pkg::*;
(
    input  logic [CF_FIRST-1:0][7:0] hdr_lo,
    input  logic [15:0]              type_en,
    input  logic [3:0]               version,
    input  logic [5:0]               flag_offset,
    output logic                     qualify,
    output logic [2:0]               flag_idx
);
    logic off_ok;
    logic ver_ok;
    logic type_ok;
    logic flag_set;

    always_comb begin
        off_ok   = (flag_offset >= 6'd2) && (flag_offset < 6'(CF_FIRST));
        flag_idx = flag_offset[2:0];
        flag_set = hdr_lo[flag_idx][7];
        ver_ok   = (version == 4'd0) || (hdr_lo[1][3:0] == version);
        type_ok  = type_en[hdr_lo[0][3:0]];
        qualify  = off_ok && flag_set && ver_ok && type_ok;
    end
endmodule

// File: rtl/ptp_cf_adder.sv
module ptp_cf_adder #(
    parameter int RES_W = 32,
    parameter int SHIFT = 16
) (
    input  logic [63:0]      cf_in,
    input  logic [RES_W-1:0] res_ns,
    output logic [63:0]      cf_out
);
    localparam int PAD = 64 - RES_W;
    logic [63:0] addend;

    always_comb begin
        addend = {{PAD{1'b0}}, res_ns} << SHIFT;
        cf_out = cf_in + addend;
    end
endmodule

// File: rtl/ptp_cf_updater.sv
module ptp_cf_updater
    import ptp_cf_pkg::*;
#(
    parameter int RES_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             out_eof,
    input  logic [15:0]      cfg_type_en,
    input  logic [3:0]       cfg_version,
    input  logic [5:0]       cfg_flag_offset,
    input  logic [RES_W-1:0] residence_ns
);
    localparam int CF_SHIFT = 16;

    cf_regs_t r_q, r_d;

    logic [HDR_LEN-1:0][7:0] view;
    logic [CF_FIRST-1:0][7:0] view_lo;
    logic                    fill_wr;
    logic                    qual_w;
    logic [2:0]              off_w;
    logic [63:0]             cf_in;
    logic [63:0]             cf_sum;
    logic                    draining;
    logic                    passing;

    // Buffer contents including the byte being written this cycle
    always_comb begin
        fill_wr = (r_q.st == ST_FILL) && in_valid && in_ready;
        view    = r_q.hdr;
        if (fill_wr) begin
            view[r_q.cnt[RD_W-1:0]] = in_data;
        end
        for (int k = 0; k < CF_FIRST; k++) begin
            view_lo[k] = view[k];
        end
        for (int k = 0; k < CF_BYTES; k++) begin
            cf_in[63 - 8*k -: 8] = view[CF_FIRST + k];
        end
    end

    ptp_cf_qualify u_qual (
        .hdr_lo      (view_lo),
        .type_en     (cfg_type_en),
        .version     (cfg_version),
        .flag_offset (cfg_flag_offset),
        .qualify     (qual_w),
        .flag_idx    (off_w)
    );

    ptp_cf_adder #(
        .RES_W (RES_W),
        .SHIFT (CF_SHIFT)
    ) u_add (
        .cf_in  (cf_in),
        .res_ns (residence_ns),
        .cf_out (cf_sum)
    );

    always_comb begin
        logic flush;
        logic last;
        r_d       = r_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_sof   = 1'b0;
        out_eof   = 1'b0;
        flush     = 1'b0;
        last      = 1'b0;
        case (r_q.st)
            ST_FILL: begin
                flush    = in_valid && in_sof && (r_q.cnt != '0);
                in_ready = !flush;
                if (flush) begin
                    // Previous frame lost its end marker: release its bytes untouched
                    r_d.st      = ST_DRAIN;
                    r_d.eof_buf = 1'b0;
                    r_d.rd      = '0;
                end else if (in_valid) begin
                    r_d.hdr = view;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == '0) begin
                        r_d.sof_buf = in_sof;
                        r_d.qual    = 1'b0;
                    end
                    if (r_q.cnt == CNT_W'(LAST_QUAL_IDX)) begin
                        r_d.qual = qual_w;
                        r_d.off  = off_w;
                    end
                    if (r_q.cnt == CNT_W'(HDR_LEN - 1) && r_q.qual) begin
                        for (int k = 0; k < CF_BYTES; k++) begin
                            r_d.hdr[CF_FIRST + k] = cf_sum[63 - 8*k -: 8];
                        end
                        r_d.hdr[r_q.off][7] = 1'b0;
                    end
                    if (in_eof || r_q.cnt == CNT_W'(HDR_LEN - 1)) begin
                        r_d.st      = ST_DRAIN;
                        r_d.eof_buf = in_eof;
                        r_d.rd      = '0;
                    end
                end
            end
            ST_DRAIN: begin
                last      = ({1'b0, r_q.rd} == r_q.cnt - 1'b1);
                out_valid = 1'b1;
                out_data  = r_q.hdr[r_q.rd];
                out_sof   = (r_q.rd == '0) && r_q.sof_buf;
                out_eof   = last && r_q.eof_buf;
                if (out_ready) begin
                    r_d.rd = r_q.rd + 1'b1;
                    if (last) begin
                        r_d.cnt = '0;
                        r_d.st  = (r_q.eof_buf || r_q.cnt != CNT_W'(HDR_LEN)) ? ST_FILL : ST_PASS;
                    end
                end
            end
            ST_PASS: begin
                out_valid = in_valid && !in_sof;
                out_data  = in_data;
                out_eof   = in_eof;
                in_ready  = out_ready && !in_sof;
                if (in_valid && in_sof) begin
                    r_d.st = ST_FILL;
                end else if (in_valid && out_ready && in_eof) begin
                    r_d.st = ST_FILL;
                end
            end
            default: r_d.st = ST_FILL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign draining = (r_q.st == ST_DRAIN);
    assign passing  = (r_q.st == ST_PASS);

endmodule

// File: rtl/ptp_cf_updater_chk.sv
module ptp_cf_updater_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       in_eof,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_sof,
    input logic       out_eof,
    input logic       draining,
    input logic       passing
);
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        draining && out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)); // R9

    AST_DRAIN_PRESENTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(draining) |-> out_valid); // R9

    AST_PASS_NO_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        passing && out_valid |-> !out_sof); // R8

    AST_EOF_ENDS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_eof |=> !passing); // R7

    AST_OUT_EOF_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_eof |=> !passing && !draining); // R8
endmodule

bind ptp_cf_updater ptp_cf_updater_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_eof    (in_eof),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .draining  (draining),
    .passing   (passing)
);

// File: tb/ptp_cf_updater_tb_top.sv
module ptp_cf_updater_tb_top;
    localparam int RES_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [7:0]       in_data = 8'h00;
    logic             in_sof = 1'b0;
    logic             in_eof = 1'b0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [7:0]       out_data;
    logic             out_sof;
    logic             out_eof;
    logic [15:0]      cfg_mask = 16'hFFFF;
    logic [3:0]       cfg_ver = 4'd2;
    logic [5:0]       cfg_off = 6'd5;
    logic [RES_W-1:0] cfg_res = '0;

    int n_checks = 0;
    int n_fail = 0;
    int ready_pct = 100;
    bit done = 1'b0;

    logic [7:0] frm[$];
    logic [7:0] exp_q[$];
    logic [7:0] oq_d[$];
    bit         oq_s[$];
    bit         oq_e[$];

    always #10 clk = ~clk;

    ptp_cf_updater #(.RES_W(RES_W)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .in_valid        (in_valid),
        .in_ready        (in_ready),
        .in_data         (in_data),
        .in_sof          (in_sof),
        .in_eof          (in_eof),
        .out_valid       (out_valid),
        .out_ready       (out_ready),
        .out_data        (out_data),
        .out_sof         (out_sof),
        .out_eof         (out_eof),
        .cfg_type_en     (cfg_mask),
        .cfg_version     (cfg_ver),
        .cfg_flag_offset (cfg_off),
        .residence_ns    (cfg_res)
    );

    task automatic finish_run();
        done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        finish_run();
    end

    // Output collector: ready set after posedge, transfer sampled at negedge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            out_ready = ($urandom % 100) < ready_pct;
            @(negedge clk);
            if (rst_n && out_valid && out_ready) begin
                oq_d.push_back(out_data);
                oq_s.push_back(out_sof);
                oq_e.push_back(out_eof);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Frame builder: random bytes, then header fields placed
    task automatic make_frame(input int len, input logic [3:0] mtype, input logic [3:0] ver,
                              input int off, input bit flag, input logic [63:0] cf);
        frm.delete();
        for (int i = 0; i < len; i++) frm.push_back(8'($urandom));
        if (len > 0) frm[0][3:0] = mtype;
        if (len > 1) frm[1][3:0] = ver;
        if (off >= 2 && off <= 7 && off < len) frm[off][7] = flag;
        for (int k = 0; k < 8; k++) if (8 + k < len) frm[8 + k] = cf[63 - 8*k -: 8];
    endtask

    // Expected output from the requirements
    task automatic build_exp();
        bit q;
        logic [63:0] cf;
        exp_q = frm;
        if (frm.size() < 16) return;
        q = (cfg_off >= 2) && (cfg_off <= 7) && frm[cfg_off][7] && cfg_mask[frm[0][3:0]]
            && (cfg_ver == 0 || frm[1][3:0] == cfg_ver);
        if (!q) return;
        for (int k = 0; k < 8; k++) cf[63 - 8*k -: 8] = frm[8 + k];
        cf = cf + ({{(64 - RES_W){1'b0}}, cfg_res} << 16);
        for (int k = 0; k < 8; k++) exp_q[8 + k] = cf[63 - 8*k -: 8];
        exp_q[cfg_off][7] = 1'b0;
    endtask

    task automatic send_frame();
        for (int i = 0; i < frm.size(); i++) begin
            in_data  = frm[i];
            in_sof   = (i == 0);
            in_eof   = (i == frm.size() - 1);
            in_valid = 1'b1;
            forever begin
                @(negedge clk);
                if (in_ready) break;
            end
            @(posedge clk);
            #1;
            in_valid = 1'b0;
            in_sof   = 1'b0;
            in_eof   = 1'b0;
            if (($urandom % 4) == 0) begin
                @(posedge clk);
                #1;
            end
        end
    endtask

    task automatic run_frame(input string req);
        int wait_cyc;
        bit data_ok;
        bit mark_ok;
        int bad;
        oq_d.delete(); oq_s.delete(); oq_e.delete();
        build_exp();
        send_frame();
        wait_cyc = 0;
        while (oq_d.size() < exp_q.size() && wait_cyc < 2000) begin
            @(posedge clk);
            wait_cyc++;
        end
        repeat (3) @(posedge clk);
        #1;
        data_ok = (oq_d.size() == exp_q.size());
        bad = -1;
        if (data_ok) begin
            for (int i = 0; i < exp_q.size(); i++) begin
                if (oq_d[i] !== exp_q[i]) begin
                    data_ok = 1'b0;
                    if (bad < 0) bad = i;
                end
            end
        end
        if (bad >= 0)
            chk(data_ok, req, $sformatf("byte %0d", bad), 64'(oq_d[bad]), 64'(exp_q[bad]));
        else
            chk(data_ok, req, "frame length", 64'(oq_d.size()), 64'(exp_q.size()));
        mark_ok = (oq_d.size() == exp_q.size()) && (oq_d.size() > 0);
        if (mark_ok) begin
            for (int i = 0; i < oq_s.size(); i++) begin
                if (oq_s[i] != (i == 0)) mark_ok = 1'b0;
                if (oq_e[i] != (i == oq_e.size() - 1)) mark_ok = 1'b0;
            end
        end
        chk(mark_ok, "R8", "sof/eof placement", 64'(mark_ok), 64'(1));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(out_valid == 1'b0, "R11", "out_valid after reset", 64'(out_valid), 64'(0));
        chk(in_ready == 1'b1, "R11", "in_ready after reset", 64'(in_ready), 64'(1));
        @(posedge clk);
        #1;

        // R5 R6: qualifying frame
        cfg_mask = 16'h0001; cfg_ver = 4'd2; cfg_off = 6'd5; cfg_res = 32'h0000_1234;
        make_frame(24, 4'd0, 4'd2, 5, 1'b1, 64'h0000_0000_0001_0000);
        run_frame("R5");
        chk(oq_d.size() > 15 && oq_d[5][7] == 1'b0, "R6", "flag bit cleared",
            oq_d.size() > 5 ? 64'(oq_d[5][7]) : 64'hx, 64'(0));
        // R5: wraparound
        cfg_res = 32'hFFFF_FFFF;
        make_frame(20, 4'd0, 4'd2, 5, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        run_frame("R5");
        // R1: flag clear
        make_frame(20, 4'd0, 4'd2, 5, 1'b0, 64'h0123_4567_89AB_CDEF);
        run_frame("R1");
        // R2: bad offsets and offset 7
        cfg_off = 6'd0;
        make_frame(20, 4'd0, 4'd2, 5, 1'b1, 64'h10);
        frm[0][7] = 1'b1;
        run_frame("R2");
        cfg_off = 6'd1;
        make_frame(20, 4'd0, 4'd2, 5, 1'b1, 64'h10);
        frm[1][7] = 1'b1;
        run_frame("R2");
        cfg_off = 6'd8;
        make_frame(20, 4'd0, 4'd2, 5, 1'b1, 64'h10);
        frm[8][7] = 1'b1;
        run_frame("R2");
        cfg_off = 6'd7;
        make_frame(20, 4'd0, 4'd2, 7, 1'b1, 64'h20);
        run_frame("R2");
        // R3: type disabled
        cfg_off = 6'd5; cfg_mask = 16'hFFF7;
        make_frame(20, 4'd3, 4'd2, 5, 1'b1, 64'h30);
        run_frame("R3");
        cfg_mask = 16'h0008;
        make_frame(20, 4'd3, 4'd2, 5, 1'b1, 64'h30);
        run_frame("R3");
        // R4: version mismatch, then version 0 accepts version 1 nibble
        cfg_mask = 16'hFFFF; cfg_ver = 4'd2;
        make_frame(20, 4'd1, 4'd1, 5, 1'b1, 64'h40);
        run_frame("R4");
        cfg_ver = 4'd0;
        make_frame(20, 4'd1, 4'd1, 5, 1'b1, 64'h40);
        run_frame("R4");
        // R7: short frame and exactly 16 bytes
        cfg_ver = 4'd2;
        make_frame(10, 4'd0, 4'd2, 5, 1'b1, 64'h50);
        run_frame("R7");
        make_frame(16, 4'd0, 4'd2, 5, 1'b1, 64'h50);
        run_frame("R7");
        // R9: heavy backpressure, long frame
        ready_pct = 20;
        make_frame(40, 4'd9, 4'd2, 5, 1'b1, 64'h0000_00FF_FFFF_0000);
        run_frame("R9");
        ready_pct = 100;

        // R10 and random mix
        for (int n = 0; n < 40; n++) begin
            cfg_mask  = 16'($urandom);
            cfg_ver   = (($urandom % 3) == 0) ? 4'd0 : 4'd2;
            cfg_off   = (($urandom % 2) == 0) ? 6'd5 : 6'($urandom % 10);
            cfg_res   = $urandom;
            ready_pct = 30 + ($urandom % 71);
            make_frame(5 + ($urandom % 36), 4'($urandom), (($urandom % 4) == 0) ? 4'd1 : 4'd2,
                       int'(cfg_off), 1'($urandom), {$urandom, $urandom});
            run_frame("R10");
        end
        ready_pct = 100;
        finish_run();
    end
endmodule